// File: doc/BRIEF.md
# One-Time-Programmable Array Programming Controller

This block sits between a host bus and a one-time-programmable memory array and carries out single-word program and read-back operations on that array. The host sees three registers, chosen by a two-bit select: a word address, a data word, and a control/status register. Writing a command code into the control register starts either a program operation or a read-back operation on the word that the address register selects.

A program operation drives the array's program strobe for a fixed, parameterised number of clock cycles (about 100 µs at the system clock) and then finishes. There is no verify-and-retry loop. The array stores the bitwise AND of the old and new contents, because blank cells read as all ones and a pulse can only clear bits. Programming is refused unless the device is in host programming mode and the programming-voltage qualifier is asserted. Read-back is refused while that qualifier shows the high programming level. While host programming mode is active, a plain read of the data register returns a dummy zero word unless the register holds a word fetched by a completed read-back command.

Top module: `otp_prog_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the address register reads 0, the data register reads 0, the status register reads 0, and cell_pgm and cell_rd are low.
- R2: A control write whose bits [1:0] are 2'b01 (program), accepted while prog_mode and vpp_high are both high, raises cell_pgm from the next cycle for exactly PULSE_CYC cycles, with cell_addr and cell_wdata equal to the address and data registers. Status bit 0 (busy) is high for those cycles. Afterwards busy is 0 and status bit 1 (done) is 1.
- R3: A program command accepted while prog_mode or vpp_high is low produces no cell_pgm pulse and sets status bit 2 (error) on the next cycle, with done 0. The array word stays unchanged.
- R4: A control write with bits [1:0] = 2'b10 (read-back), accepted while vpp_high is low, gives a one-cycle cell_rd pulse in the next cycle. One cycle later the word is loaded into the data register and done is set. Busy covers both cycles.
- R5: A read-back command accepted while vpp_high is high produces no cell_rd pulse and sets error.
- R6: While prog_mode is high, reading the data register (select 1) returns 16'h0000 unless a read-back has completed since the last accepted address write, data write or command. Outside prog_mode it returns the register's contents.
- R7: While busy, host writes to the address (select 0), data (select 1) and control (select 2) registers are ignored.
- R8: Programming an already-programmed word leaves it equal to the AND of the old contents and the new data, as seen by a later read-back.
- R9: An accepted command clears done and error before the new operation runs. Busy, done and error are never high together in pairs. Control codes 2'b00 and 2'b11 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_mode | input | 1 | Device is in host programming mode |
| vpp_high | input | 1 | Programming voltage present (above normal supply level) |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register select: 0 address, 1 data, 2 control/status, 3 reads zero |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for the selected register (combinational) |
| cell_addr | output | 15 | Array word address |
| cell_wdata | output | 16 | Array program data |
| cell_pgm | output | 1 | Array program strobe, held for the pulse length |
| cell_rd | output | 1 | Array read strobe; array returns cell_rdata one cycle later |
| cell_rdata | input | 16 | Array read data |

## Verification
The bound checker watches every cycle for the safety rules: a program strobe only starts after a cycle in which programming mode and high voltage were both present, and a read strobe only starts after a cycle without high voltage. It also checks that the read strobe lasts one cycle, that the address and program data hold still during an operation, and that busy, done and error stay mutually exclusive. The exact pulse length, the dummy-zero rule for data reads, the bit-clearing array contents and the writes ignored while busy depend on the history of commands. Only the bench's reference model and its scenarios show these: repeated programming of one word, refused operations, writes during a pulse, and the highest word address.

// File: rtl/otp_pkg.sv
// Package: shared encodings for the OTP programming controller.
// Assumes a 2-bit host register select and 2-bit command field.
package otp_pkg;
    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        CMD_NOP0 = 2'b00,
        CMD_PROG = 2'b01,
        CMD_READ = 2'b10,
        CMD_NOP3 = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PGM   = 2'd1,
        ST_RDREQ = 2'd2,
        ST_RDCAP = 2'd3
    } op_state_e;
endpackage

// File: rtl/otp_pulse_timer.sv
// Module: down-counter timing the program pulse.
// After load, expire rises when PULSE_CYC-1 further cycles have passed,
// so a state held until expire lasts PULSE_CYC cycles. Assumes PULSE_CYC >= 1.
module otp_pulse_timer #(
    parameter int PULSE_CYC = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);
    localparam int CW = $clog2(PULSE_CYC + 1);
    logic [CW-1:0] cnt;

    // Load the pulse length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= CW'(PULSE_CYC - 1);
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expire = (cnt == '0);
endmodule

// File: rtl/otp_host_regs.sv
// Module: host-visible address and data registers plus read-back-valid flag.
// Host writes are accepted only while the sequencer is idle; the data
// register also loads read-back words from the array.
module otp_host_regs
    import otp_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              busy,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] cap_data,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              rd_valid,
    output logic              cmd_acc,
    output logic [1:0]        cmd_code
);
    logic wr_ok;

    // Decode accepted writes and valid command codes.
    always_comb begin
        wr_ok    = host_we && !busy;
        cmd_code = host_wdata[1:0];
        cmd_acc  = wr_ok && (host_sel == SEL_CTRL) &&
                   (cmd_code == CMD_PROG || cmd_code == CMD_READ);
    end

    // Address register: host write only.
    always_ff @(posedge clk) begin
        if (!rst_n)                             addr_q <= '0;
        else if (wr_ok && host_sel == SEL_ADDR) addr_q <= host_wdata[ADDR_W-1:0];
    end

    // Data register: host write or array read-back capture.
    always_ff @(posedge clk) begin
        if (!rst_n)                             data_q <= '0;
        else if (cap_en)                        data_q <= cap_data;
        else if (wr_ok && host_sel == SEL_DATA) data_q <= host_wdata;
    end

    // Read-back-valid flag: set by capture, cleared by any other accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_valid <= 1'b0;
        else if (cap_en) rd_valid <= 1'b1;
        else if (cmd_acc || (wr_ok && (host_sel == SEL_ADDR || host_sel == SEL_DATA)))
                         rd_valid <= 1'b0;
    end
endmodule

// File: rtl/otp_op_seq.sv
// Module: operation sequencer for program and read-back commands.
// Checks the mode and voltage qualifiers at command time, drives the array
// strobes and keeps done/error status. Assumes cmd_acc only when idle.
module otp_op_seq
    import otp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_acc,
    input  logic [1:0] cmd_code,
    input  logic       prog_mode,
    input  logic       vpp_high,
    input  logic       expire,
    output logic       tmr_load,
    output logic       cell_pgm,
    output logic       cell_rd,
    output logic       cap_en,
    output logic       busy,
    output logic       done,
    output logic       err
);
    op_state_e state, state_n;
    logic      start_pgm, start_rd, refuse;

    // Classify an accepted command against the qualifiers.
    always_comb begin
        start_pgm = cmd_acc && cmd_code == CMD_PROG && prog_mode && vpp_high;
        start_rd  = cmd_acc && cmd_code == CMD_READ && !vpp_high;
        refuse    = cmd_acc && !start_pgm && !start_rd;
        tmr_load  = start_pgm;
    end

    // Next-state selection.
    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE:  if (start_pgm) state_n = ST_PGM;
                      else if (start_rd) state_n = ST_RDREQ;
            ST_PGM:   if (expire) state_n = ST_IDLE;
            ST_RDREQ: state_n = ST_RDCAP;
            ST_RDCAP: state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Done/error status: cleared on a new command, set on completion or refusal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else if (cmd_acc) begin
            done <= 1'b0;
            err  <= refuse;
        end else if ((state == ST_PGM && expire) || state == ST_RDCAP) begin
            done <= 1'b1;
        end
    end

    assign cell_pgm = (state == ST_PGM);
    assign cell_rd  = (state == ST_RDREQ);
    assign cap_en   = (state == ST_RDCAP);
    assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/otp_prog_ctrl.sv
// Module: top of the OTP programming controller.
// Joins host registers, sequencer and pulse timer, and forms the host read
// mux, including the dummy-zero data read in host programming mode.
module otp_prog_ctrl
    import otp_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 16,
    parameter int PULSE_CYC = 2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_mode,
    input  logic              vpp_high,
    input  logic              host_we,
    input  logic [1:0]        host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] cell_addr,
    output logic [DATA_W-1:0] cell_wdata,
    output logic              cell_pgm,
    output logic              cell_rd,
    input  logic [DATA_W-1:0] cell_rdata
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              rd_valid, cmd_acc, cap_en, tmr_load, expire;
    logic              busy, done, err;
    logic [1:0]        cmd_code;

    otp_host_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .busy(busy), .cap_en(cap_en),
        .cap_data(cell_rdata), .addr_q(addr_q), .data_q(data_q),
        .rd_valid(rd_valid), .cmd_acc(cmd_acc), .cmd_code(cmd_code)
    );

    otp_op_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_acc(cmd_acc), .cmd_code(cmd_code),
        .prog_mode(prog_mode), .vpp_high(vpp_high), .expire(expire),
        .tmr_load(tmr_load), .cell_pgm(cell_pgm), .cell_rd(cell_rd),
        .cap_en(cap_en), .busy(busy), .done(done), .err(err)
    );

    otp_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .expire(expire)
    );

    assign cell_addr  = addr_q;
    assign cell_wdata = data_q;

    // Host read mux; data reads give zero in host mode without a fresh read-back.
    always_comb begin
        host_rdata = '0;
        case (host_sel)
            SEL_ADDR: host_rdata = DATA_W'(addr_q);
            SEL_DATA: host_rdata = (prog_mode && !rd_valid) ? '0 : data_q;
            SEL_CTRL: host_rdata = DATA_W'({err, done, busy});
            default:  host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/otp_prog_ctrl_chk.sv
// Checker: cycle-level safety properties of the OTP programming controller,
// bound into every instance of the top module.
module otp_prog_ctrl_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_mode,
    input logic              vpp_high,
    input logic              cell_pgm,
    input logic              cell_rd,
    input logic [ADDR_W-1:0] cell_addr,
    input logic [DATA_W-1:0] cell_wdata,
    input logic              busy,
    input logic              done,
    input logic              err
);
    // R1: first cycle out of reset shows an idle controller
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && !done && !err && !cell_pgm && !cell_rd));

    // R2, R3: a pulse starts only after a cycle with mode and voltage present
    a_r2_pgm_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cell_pgm) |-> $past(prog_mode && vpp_high));

    // R2: program data and address hold during the pulse
    a_r2_pgm_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_pgm && $past(cell_pgm)) |-> ($stable(cell_wdata) && $stable(cell_addr)));

    // R3: a refusal never comes with an array strobe
    a_r3_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (!cell_pgm && !cell_rd));

    // R4: read strobe lasts one cycle
    a_r4_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        cell_rd |=> !cell_rd);

    // R5: read strobe only after a cycle without high voltage
    a_r5_rd_lowv: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cell_rd) |-> !$past(vpp_high));

    // R7: address stays put across a busy operation
    a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cell_addr));

    // R9: status flags mutually exclusive
    a_r9_status_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done, err}));
endmodule

bind otp_prog_ctrl otp_prog_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .vpp_high(vpp_high),
    .cell_pgm(cell_pgm), .cell_rd(cell_rd), .cell_addr(cell_addr),
    .cell_wdata(cell_wdata), .busy(busy), .done(done), .err(err)
);

// File: tb/test_otp_prog_ctrl.sv
// Bench: behavioural array plus a cycle-by-cycle reference model compared on
// every clock, followed by scenario checks tagged with requirements.
module test_otp_prog_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PULSE      = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_mode = 1'b1;
    logic        vpp_high = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [14:0] cell_addr;
    logic [15:0] cell_wdata;
    logic        cell_pgm, cell_rd;
    logic [15:0] cell_rdata = 16'hFFFF;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    otp_prog_ctrl #(.ADDR_W(15), .DATA_W(16), .PULSE_CYC(PULSE)) i_otp_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .vpp_high(vpp_high),
        .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .cell_addr(cell_addr), .cell_wdata(cell_wdata),
        .cell_pgm(cell_pgm), .cell_rd(cell_rd), .cell_rdata(cell_rdata)
    );

    // Array contents (blank = all ones) and reference model state
    logic [15:0] mem [int];
    int          m_left = 0;
    int          m_rd   = 0;
    logic [14:0] m_addr = '0;
    logic [15:0] m_data = '0;
    bit          m_rdv = 0, m_done = 0, m_err = 0;
    bit          cmp_on = 0;

    function automatic logic [15:0] peek(input int a);
        return mem.exists(a) ? mem[a] : 16'hFFFF;
    endfunction

    function automatic logic [15:0] model_rdata(input logic [1:0] s);
        bit bsy = (m_left > 0) || (m_rd != 0);
        case (s)
            2'd0: return {1'b0, m_addr};
            2'd1: return (prog_mode && !m_rdv) ? 16'h0000 : m_data;
            2'd2: return {13'd0, m_err, m_done, bsy};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Array behaviour and model update on each rising edge
    always @(posedge clk) begin
        bit bsy;
        cmp_on = 1;
        if (cell_pgm) mem[int'(cell_addr)] = peek(int'(cell_addr)) & cell_wdata;
        if (cell_rd) cell_rdata <= peek(int'(cell_addr));
        bsy = (m_left > 0) || (m_rd != 0);
        if (!rst_n) begin
            m_left = 0; m_rd = 0; m_addr = '0; m_data = '0;
            m_rdv = 0; m_done = 0; m_err = 0;
        end else begin
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) m_done = 1;
            end else if (m_rd == 1) m_rd = 2;
            else if (m_rd == 2) begin
                m_rd = 0; m_data = peek(int'(m_addr)); m_done = 1; m_rdv = 1;
            end
            if (host_we && !bsy) begin
                if (host_sel == 2'd0) begin m_addr = host_wdata[14:0]; m_rdv = 0; end
                if (host_sel == 2'd1) begin m_data = host_wdata; m_rdv = 0; end
                if (host_sel == 2'd2 && (host_wdata[1:0] == 2'b01 || host_wdata[1:0] == 2'b10)) begin
                    m_done = 0; m_err = 0; m_rdv = 0;
                    if (host_wdata[1:0] == 2'b01) begin
                        if (prog_mode && vpp_high) m_left = PULSE; else m_err = 1;
                    end else begin
                        if (!vpp_high) m_rd = 1; else m_err = 1;
                    end
                end
            end
        end
    end

    // Per-cycle comparison against the model (R2, R4 strobes; R6, R9 reads)
    always begin
        @(negedge clk);
        #1;
        if (cmp_on) begin
            chk("R2 cell_pgm per cycle", {15'd0, cell_pgm}, {15'd0, m_left > 0});
            chk("R4 cell_rd per cycle", {15'd0, cell_rd}, {15'd0, m_rd == 1});
            chk("R6/R9 host_rdata per cycle", host_rdata, model_rdata(host_sel));
        end
    end

    task automatic hw(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        host_sel = s; host_wdata = v; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [1:0] s, input logic [15:0] exp);
        @(negedge clk);
        host_sel = s;
        #2;
        chk(req, host_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_prog(input logic [14:0] a, input logic [15:0] d);
        hw(2'd0, {1'b0, a});
        hw(2'd1, d);
        hw(2'd2, 16'h0001);
        idle(PULSE + 2);
    endtask

    task automatic do_read(input logic [14:0] a);
        hw(2'd0, {1'b0, a});
        hw(2'd2, 16'h0002);
        idle(3);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 50000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int hi_cnt;
        repeat (3) @(negedge clk);
        // R1 reset state
        expect_reg("R1 addr after reset", 2'd0, 16'h0000);
        expect_reg("R1 status after reset", 2'd2, 16'h0000);
        prog_mode = 1'b0;
        expect_reg("R1 data after reset", 2'd1, 16'h0000);
        prog_mode = 1'b1;
        chk("R1 strobes after reset", {14'd0, cell_pgm, cell_rd}, 16'h0000);
        rst_n = 1'b1;
        idle(2);

        // R2 program with mode and voltage present; count pulse length
        vpp_high = 1'b1;
        hw(2'd0, 16'h0005);
        hw(2'd1, 16'hA5F0);
        @(negedge clk);
        host_sel = 2'd2; host_wdata = 16'h0001; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
        hi_cnt = 0;
        repeat (PULSE + 4) begin
            #1;
            if (cell_pgm) hi_cnt++;
            @(negedge clk);
        end
        chk("R2 pulse length", 16'(hi_cnt), 16'(PULSE));
        expect_reg("R2 done after program", 2'd2, 16'h0002);
        expect_reg("R6 dummy zero data read in host mode", 2'd1, 16'h0000);

        // R4 read-back with low voltage
        vpp_high = 1'b0;
        do_read(15'd5);
        expect_reg("R4 read-back word", 2'd1, 16'hA5F0);
        expect_reg("R4 done after read", 2'd2, 16'h0002);

        // R8 second program clears more bits only
        vpp_high = 1'b1;
        do_prog(15'd5, 16'h0F0F);
        vpp_high = 1'b0;
        do_read(15'd5);
        expect_reg("R8 AND of two programs", 2'd1, 16'h0500);

        // R6 write to data clears the read-back view in host mode, not outside
        hw(2'd1, 16'h1234);
        expect_reg("R6 data read zero after data write", 2'd1, 16'h0000);
        prog_mode = 1'b0;
        expect_reg("R6 data read outside host mode", 2'd1, 16'h1234);
        prog_mode = 1'b1;

        // R3 program refused without voltage
        do_prog(15'd6, 16'h0000);
        expect_reg("R3 error without voltage", 2'd2, 16'h0004);
        do_read(15'd6);
        expect_reg("R3 word untouched (no voltage)", 2'd1, 16'hFFFF);

        // R3 program refused outside host mode
        vpp_high = 1'b1; prog_mode = 1'b0;
        do_prog(15'd6, 16'h0000);
        expect_reg("R3 error outside host mode", 2'd2, 16'h0004);
        prog_mode = 1'b1;

        // R9 a good command clears error; R5 read refused with high voltage
        do_read(15'd6);
        expect_reg("R5 read refused at high voltage", 2'd2, 16'h0004);
        vpp_high = 1'b0;
        hw(2'd2, 16'h0002);
        #2;
        chk("R9 new command clears error", host_rdata, 16'h0001);
        idle(3);
        expect_reg("R3 word still blank", 2'd1, 16'hFFFF);

        // R9 ignored codes
        hw(2'd2, 16'h0003);
        expect_reg("R9 code 11 ignored", 2'd2, 16'h0002);
        hw(2'd2, 16'h0000);
        expect_reg("R9 code 00 ignored", 2'd2, 16'h0002);

        // R7 writes during a pulse are ignored; top address boundary
        vpp_high = 1'b1;
        hw(2'd0, 16'h7FFF);
        hw(2'd1, 16'h00FF);
        hw(2'd2, 16'h0001);
        hw(2'd0, 16'h0001);
        hw(2'd1, 16'hFFFF);
        hw(2'd2, 16'h0002);
        expect_reg("R7 addr write ignored while busy", 2'd0, 16'h7FFF);
        idle(PULSE + 2);
        expect_reg("R7 status after pulse", 2'd2, 16'h0002);
        vpp_high = 1'b0;
        hw(2'd2, 16'h0002);
        idle(3);
        expect_reg("R7 programmed data not overwritten", 2'd1, 16'h00FF);

        // R1 reset mid-operation returns to idle
        vpp_high = 1'b1;
        hw(2'd2, 16'h0001);
        idle(3);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        expect_reg("R1 status after reset in pulse", 2'd2, 16'h0000);
        chk("R1 no pulse after reset", {15'd0, cell_pgm}, 16'h0000);

        idle(3);
        finish_run();
    end
endmodule